// File: doc/BRIEF.md
# Two-Line Write-Through Byte Cache

This block is a very small data cache placed between a processor load/store port and a slow, byte-wide backing memory. It holds two lines of two bytes each, and any line may hold any block: the lookup compares the tag of every line and uses no index. Loads that hit are answered from the cache. A load or store that misses first brings the whole block in from memory and makes it resident. Every store also writes its byte through to memory. Lines therefore never differ from memory, and replacing one never costs a memory write.

The processor gives one request at a time. It raises `cpu_valid` for one cycle with the address, the direction and the store byte, holds those fields and waits for the one-cycle `cpu_done` before it issues the next request. The memory side uses a request/acknowledge pair. The cache holds `mem_req` and its fields steady until `mem_ack` arrives, after any number of wait cycles. Two counters record hits and misses for self-checking.

Top module: `wt_cache`

## Requirements
- R1: After reset both lines are invalid, `hit_count` and `miss_count` are zero, and `cpu_done` and `mem_req` are low. The first access after reset is therefore a miss.
- R2: Address bits [3:1] form the tag and bit [0] selects the byte within the block. A request hits when a valid line holds its tag, and at most one line ever matches.
- R3: A load miss performs exactly two memory reads, to the block's byte 0 (address {tag,0}) and then byte 1 (address {tag,1}). It then returns the requested byte on `cpu_rdata` together with `cpu_done`.
- R4: A load hit returns the cached byte and causes no memory traffic.
- R5: Every store, hit or miss, performs exactly one memory write of its byte to its own address (`mem_we`=1). `cpu_done` follows that write's acknowledge. A store hit updates the line and memory within the same request.
- R6: A store miss allocates the block (two reads) and merges the store byte into the line, so later loads of that byte hit and return the stored value.
- R7: A fill uses an invalid line when one exists. Otherwise it replaces the line that was least recently touched, where a hit or a fill touches a line.
- R8: Replacing a line causes no memory write. A load performs no memory write at all.
- R9: `hit_count` rises by one per hit request and `miss_count` by one per miss request. A single request never moves both.
- R10: Any number of wait cycles before `mem_ack` is tolerated. While a memory request waits, its address, direction and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | One-cycle request strobe, taken when the block is idle |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 4 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load result, valid with cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for memory write, 0 for read |
| mem_addr | output | 4 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge |
| hit_count | output | 16 | Number of hit requests |
| miss_count | output | 16 | Number of miss requests |

## Verification
On a store miss, the last fill read returns from memory in the same cycle that the store byte is merged into the line being written. A store to offset 1 is the sharpest case, because that byte arrives on the final read. The bench issues such stores at both offsets with varied memory wait counts. It then loads both bytes, which must hit: the stored offset must return the store byte and the other offset the memory byte. A store hit also updates the line in the same cycle that the cache decides its memory write. This case is judged by an immediate reload that must hit and return the new byte, and by the memory image, which must hold that byte.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_WRITE
  } ctrl_state_e;
endpackage

// File: rtl/wt_cache_lines.sv
module wt_cache_lines #(
  parameter int LINES  = 2,
  parameter int TAG_W  = 3,
  parameter int OFF_W  = 1,
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TAG_W-1:0]            look_tag,
  input  logic [OFF_W-1:0]            look_off,
  input  logic                        touch_en,
  input  logic [$clog2(LINES)-1:0]    touch_idx,
  input  logic                        fill_en,
  input  logic [$clog2(LINES)-1:0]    fill_idx,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [(DATA_W<<OFF_W)-1:0]  fill_data,
  input  logic                        wr_en,
  input  logic [$clog2(LINES)-1:0]    wr_idx,
  input  logic [OFF_W-1:0]            wr_off,
  input  logic [DATA_W-1:0]           wr_data,
  output logic                        hit,
  output logic [$clog2(LINES)-1:0]    hit_idx,
  output logic [DATA_W-1:0]           rd_byte,
  output logic [$clog2(LINES)-1:0]    victim_idx
);
  localparam int IDX_W = $clog2(LINES);
  localparam int BLK_W = DATA_W << OFF_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];
  logic [BLK_W-1:0] blk_q [LINES];
  logic [IDX_W-1:0] age_q [LINES];
  logic [LINES-1:0] hit_vec;

  // per-line tag comparators
  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign rd_byte = blk_q[hit_idx][look_off*DATA_W +: DATA_W];

  // empty line first, else the oldest one
  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (!valid_q[i] && !found) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    if (!found)
      for (int i = 0; i < LINES; i++)
        if (age_q[i] == IDX_W'(LINES-1)) victim_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        blk_q[i] <= '0;
        age_q[i] <= IDX_W'(i);
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (fill_en && fill_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= fill_tag;
          blk_q[i]   <= fill_data;
        end else if (wr_en && wr_idx == IDX_W'(i)) begin
          blk_q[i][wr_off*DATA_W +: DATA_W] <= wr_data;
        end
        if (touch_en) begin
          if (touch_idx == IDX_W'(i)) age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end

  assert_hit_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_victim_empty_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q != {LINES{1'b1}}) |-> !valid_q[victim_idx]);

  assert_fill_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_tag));
endmodule

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 1,
  parameter int LINES  = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_valid,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [DATA_W-1:0]             cpu_wdata,
  output logic [DATA_W-1:0]             cpu_rdata,
  output logic                          cpu_done,
  input  logic                          hit,
  input  logic [$clog2(LINES)-1:0]      hit_idx,
  input  logic [DATA_W-1:0]             rd_byte,
  input  logic [$clog2(LINES)-1:0]      victim_idx,
  output logic [ADDR_W-OFF_W-1:0]       look_tag,
  output logic [OFF_W-1:0]              look_off,
  output logic                          touch_en,
  output logic [$clog2(LINES)-1:0]      touch_idx,
  output logic                          fill_en,
  output logic [$clog2(LINES)-1:0]      fill_idx,
  output logic [(DATA_W<<OFF_W)-1:0]    fill_data,
  output logic                          wr_en,
  output logic [$clog2(LINES)-1:0]      wr_idx,
  output logic [OFF_W-1:0]              wr_off,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          ev_hit,
  output logic                          ev_miss,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [DATA_W-1:0]             mem_wdata,
  input  logic [DATA_W-1:0]             mem_rdata,
  input  logic                          mem_ack
);
  localparam int IDX_W = $clog2(LINES);
  localparam int BYTES = 1 << OFF_W;
  localparam int BLK_W = DATA_W * BYTES;

  function automatic logic [BLK_W-1:0] put_byte(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_W-1:0] off,
                                                input logic [DATA_W-1:0] b);
    blk[off*DATA_W +: DATA_W] = b;
    return blk;
  endfunction

  function automatic logic [DATA_W-1:0] get_byte(input logic [BLK_W-1:0] blk,
                                                 input logic [OFF_W-1:0] off);
    return blk[off*DATA_W +: DATA_W];
  endfunction

  ctrl_state_e       state_q;
  logic              r_we;
  logic [ADDR_W-1:0] r_addr;
  logic [DATA_W-1:0] r_wdata;
  logic [IDX_W-1:0]  r_vic;
  logic [OFF_W-1:0]  beat_q;
  logic [BLK_W-1:0]  buf_q;
  logic [BLK_W-1:0]  assembled;
  logic              last_beat;
  logic              fill_last_ack;

  assign look_tag      = r_addr[ADDR_W-1:OFF_W];
  assign look_off      = r_addr[OFF_W-1:0];
  assign last_beat     = (beat_q == OFF_W'(BYTES-1));
  assign assembled     = put_byte(buf_q, beat_q, mem_rdata);
  assign fill_last_ack = (state_q == ST_FILL) && mem_ack && last_beat;

  // named events
  assign ev_hit    = (state_q == ST_LOOK) && hit;
  assign ev_miss   = (state_q == ST_LOOK) && !hit;
  assign touch_en  = ev_hit || fill_last_ack;
  assign touch_idx = ev_hit ? hit_idx : r_vic;
  assign fill_en   = fill_last_ack;
  assign fill_idx  = r_vic;
  assign fill_data = r_we ? put_byte(assembled, look_off, r_wdata) : assembled;
  assign wr_en     = ev_hit && r_we;
  assign wr_idx    = hit_idx;
  assign wr_off    = look_off;
  assign wr_data   = r_wdata;

  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? r_addr : {look_tag, beat_q};
  assign mem_wdata = r_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      r_we      <= 1'b0;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_vic     <= '0;
      beat_q    <= '0;
      buf_q     <= '0;
      cpu_rdata <= '0;
      cpu_done  <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (cpu_valid) begin
          r_we    <= cpu_we;
          r_addr  <= cpu_addr;
          r_wdata <= cpu_wdata;
          state_q <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          if (r_we) state_q <= ST_WRITE;
          else begin
            cpu_rdata <= rd_byte;
            cpu_done  <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end else begin
          r_vic   <= victim_idx;
          beat_q  <= '0;
          state_q <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          buf_q  <= assembled;
          beat_q <= beat_q + 1'b1;
          if (last_beat) begin
            if (r_we) state_q <= ST_WRITE;
            else begin
              cpu_rdata <= get_byte(assembled, look_off);
              cpu_done  <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
        end
        ST_WRITE: if (mem_ack) begin
          cpu_done <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_store_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && r_we |-> $past(mem_req && mem_we && mem_ack));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_load_never_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !r_we |-> !mem_we);
endmodule

// File: rtl/wt_cache_counters.sv
module wt_cache_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  logic             ev_miss,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else begin
      if (ev_hit)  hit_count  <= hit_count + 1'b1;
      if (ev_miss) miss_count <= miss_count + 1'b1;
    end
  end

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_hit && ev_miss));

  assert_hit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> hit_count == CNT_W'($past(hit_count) + 1'b1) && $stable(miss_count));
endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 1,
  parameter int LINES  = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int BLK_W = DATA_W << OFF_W;

  logic              hit, touch_en, fill_en, wr_en, ev_hit, ev_miss;
  logic [IDX_W-1:0]  hit_idx, victim_idx, touch_idx, fill_idx, wr_idx;
  logic [DATA_W-1:0] rd_byte, wr_data;
  logic [TAG_W-1:0]  look_tag;
  logic [OFF_W-1:0]  look_off, wr_off;
  logic [BLK_W-1:0]  fill_data;

  wt_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .LINES(LINES)) ctrl_i (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
    .hit, .hit_idx, .rd_byte, .victim_idx, .look_tag, .look_off,
    .touch_en, .touch_idx, .fill_en, .fill_idx, .fill_data,
    .wr_en, .wr_idx, .wr_off, .wr_data, .ev_hit, .ev_miss,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
  );

  wt_cache_lines #(.LINES(LINES), .TAG_W(TAG_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) lines_i (
    .clk, .rst_n, .look_tag, .look_off, .touch_en, .touch_idx,
    .fill_en, .fill_idx, .fill_tag(look_tag), .fill_data,
    .wr_en, .wr_idx, .wr_off, .wr_data,
    .hit, .hit_idx, .rd_byte, .victim_idx
  );

  wt_cache_counters #(.CNT_W(CNT_W)) cnt_i (
    .clk, .rst_n, .ev_hit, .ev_miss, .hit_count, .miss_count
  );
endmodule

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [3:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic       cpu_done;
  logic       mem_req, mem_we;
  logic [3:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic       mem_ack = 1'b0;
  logic [15:0] hit_count, miss_count;

  always #5 clk = ~clk;

  wt_cache dut_i (
    .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
    .hit_count, .miss_count
  );

  int tests = 0, fails = 0;
  int exp_hit = 0, exp_miss = 0;
  int cyc = 0;
  bit timeout = 1'b0;

  // backing memory model
  logic [7:0] mem [16];
  int   wait_cycles = 0;
  int   waitc = 0;
  int   rd_cnt = 0, wr_cnt = 0, stab_err = 0;
  logic [3:0] rd_hist [64];
  logic [3:0] last_wr_addr = '0;
  logic [7:0] last_wr_data = '0;
  logic [3:0] cap_addr = '0;
  logic       cap_we = 1'b0;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) timeout <= 1'b1;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      waitc   <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
      waitc   <= 0;
    end else if (mem_req) begin
      if (waitc == 0) begin
        cap_addr <= mem_addr;
        cap_we   <= mem_we;
      end else if (mem_addr != cap_addr || mem_we != cap_we) begin
        stab_err <= stab_err + 1;
      end
      if (waitc >= wait_cycles) begin
        mem_ack <= 1'b1;
        waitc   <= 0;
        if (mem_we) begin
          mem[mem_addr] <= mem_wdata;
          last_wr_addr  <= mem_addr;
          last_wr_data  <= mem_wdata;
          wr_cnt        <= wr_cnt + 1;
        end else begin
          mem_rdata          <= mem[mem_addr];
          rd_hist[rd_cnt%64] <= mem_addr;
          rd_cnt             <= rd_cnt + 1;
        end
      end else begin
        waitc <= waitc + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int last_nrd, last_nwr, first_rd;

  task automatic access(input bit we, input logic [3:0] addr, input logic [7:0] wd,
                        output logic [7:0] rd);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    @(negedge clk);
    cpu_valid = 1'b0;
    while (!cpu_done && !timeout) @(negedge clk);
    rd = cpu_rdata;
    last_nrd = rd_cnt - r0;
    last_nwr = wr_cnt - w0;
    first_rd = r0;
  endtask

  task automatic chk_counts(input string req);
    chk({req, " hit_count"}, int'(hit_count), exp_hit);
    chk({req, " miss_count"}, int'(miss_count), exp_miss);
  endtask

  task automatic t_reset();
    chk("R1 reset hit_count", int'(hit_count), 0);
    chk("R1 reset miss_count", int'(miss_count), 0);
    chk("R1 reset cpu_done", int'(cpu_done), 0);
    chk("R1 reset mem_req", int'(mem_req), 0);
  endtask

  task automatic t_first_load_miss();
    logic [7:0] rd;
    wait_cycles = 3;
    access(1'b0, 4'd1, 8'h00, rd);
    exp_miss++;
    chk("R1 first access misses", int'(miss_count), exp_miss);
    chk("R3 load miss data", int'(rd), int'(init_val(1)));
    chk("R3 load miss read count", last_nrd, 2);
    chk("R3 first fill address", int'(rd_hist[first_rd%64]), 0);
    chk("R3 second fill address", int'(rd_hist[(first_rd+1)%64]), 1);
    chk("R8 load writes nothing", last_nwr, 0);
    chk("R10 stable while waiting", stab_err, 0);
    chk_counts("R9");
  endtask

  task automatic t_empty_line_first();
    logic [7:0] rd;
    wait_cycles = 0;
    access(1'b0, 4'd7, 8'h00, rd);
    exp_miss++;
    chk("R3 zero-wait miss data", int'(rd), int'(init_val(7)));
    chk("R10 zero-wait read count", last_nrd, 2);
    access(1'b0, 4'd0, 8'h00, rd);
    exp_hit++;
    chk("R7 empty line used, first block kept", int'(rd), int'(init_val(0)));
    chk("R4 hit has no memory reads", last_nrd, 0);
    chk("R4 hit has no memory writes", last_nwr, 0);
    chk_counts("R9");
  endtask

  task automatic t_store_miss_off1();
    logic [7:0] rd;
    wait_cycles = 2;
    access(1'b1, 4'd5, 8'hA5, rd);
    exp_miss++;
    chk("R6 store miss fills block", last_nrd, 2);
    chk("R5 store miss one write", last_nwr, 1);
    chk("R5 write address", int'(last_wr_addr), 5);
    chk("R5 write data", int'(last_wr_data), 8'hA5);
    chk("R5 memory image", int'(mem[5]), 8'hA5);
    chk_counts("R9");
  endtask

  task automatic t_lru_replace();
    logic [7:0] rd;
    wait_cycles = 1;
    access(1'b0, 4'd7, 8'h00, rd);
    exp_miss++;
    chk("R7 oldest line was replaced", last_nrd, 2);
    chk("R8 replacement writes nothing", last_nwr, 0);
    chk("R3 refetched data", int'(rd), int'(init_val(7)));
    access(1'b0, 4'd5, 8'h00, rd);
    exp_hit++;
    chk("R6 merged byte at offset 1", int'(rd), 8'hA5);
    access(1'b0, 4'd4, 8'h00, rd);
    exp_hit++;
    chk("R6 other byte from memory", int'(rd), int'(init_val(4)));
    access(1'b0, 4'd0, 8'h00, rd);
    exp_miss++;
    chk("R7 older block evicted", last_nrd, 2);
    chk_counts("R9");
  endtask

  task automatic t_store_hit();
    logic [7:0] rd;
    wait_cycles = 4;
    access(1'b1, 4'd4, 8'h3C, rd);
    exp_hit++;
    chk("R5 store hit no reads", last_nrd, 0);
    chk("R5 store hit one write", last_nwr, 1);
    chk("R5 store hit memory image", int'(mem[4]), 8'h3C);
    chk("R10 stable during long wait", stab_err, 0);
    access(1'b0, 4'd4, 8'h00, rd);
    exp_hit++;
    chk("R5 store hit updated line", int'(rd), 8'h3C);
    chk("R4 reload has no reads", last_nrd, 0);
    chk_counts("R9");
  endtask

  task automatic t_store_miss_off0();
    logic [7:0] rd;
    wait_cycles = 1;
    access(1'b1, 4'd8, 8'h77, rd);
    exp_miss++;
    chk("R6 offset 0 store fills", last_nrd, 2);
    chk("R5 offset 0 store writes", last_nwr, 1);
    chk("R5 offset 0 memory image", int'(mem[8]), 8'h77);
    access(1'b0, 4'd8, 8'h00, rd);
    exp_hit++;
    chk("R6 merged byte at offset 0", int'(rd), 8'h77);
    access(1'b0, 4'd9, 8'h00, rd);
    exp_hit++;
    chk("R2 neighbour byte same block", int'(rd), int'(init_val(9)));
    access(1'b0, 4'd5, 8'h00, rd);
    exp_hit++;
    chk("R7 recently used block kept", int'(rd), 8'hA5);
    chk_counts("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_load_miss();
    t_empty_line_first();
    t_store_miss_off1();
    t_lru_replace();
    t_store_hit();
    t_store_miss_off0();
    if (timeout) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule